// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block is a master-side synchronous serial port that exchanges 16-bit words with an external controller. It makes its own serial clock by dividing the system clock with a programmable divider. It also makes its own active-high frame-sync pulse. The serial clock runs without stopping after reset and idles low only while reset is held. When the enable input rises, one frame-sync pulse opens the exchange. Words then move in both directions, one after another with no gap, until enable is dropped. The port then stops at the next word boundary.

Transmit words enter through a parallel input. The block takes one word each time a strobe is pulsed, and the strobe is pulsed just before the word starts to shift. Received words are packed MSB first and presented with a one-cycle strobe. A group flag toggles once after every complete group of received words. A control state machine has three states:

- `ST_IDLE`: waiting for enable.
- `ST_SYNC`: frame sync is high for one serial-clock period.
- `ST_SHIFT`: words are streaming.

It makes four transitions, each on a rising serial-clock tick:

- **start**: `ST_IDLE` to `ST_SYNC`, while enable is high.
- **open**: `ST_SYNC` to `ST_SHIFT`, which always loads the first word.
- **reload**: `ST_SHIFT` to `ST_SHIFT` at a word boundary while enable is still high.
- **stop**: `ST_SHIFT` to `ST_IDLE` at a word boundary once enable is low.

Top module: `ssp_framer`

## Requirements
- R1: `sclk` toggles every `div_n`+1 system cycles, so one serial period lasts 2×(`div_n`+1) system cycles. It runs continuously after reset, whether or not a transfer is in progress.
- R2: `fsync` is active high. It rises on the first `sclk` rising edge after `en` is seen high in the idle state, and it stays high for exactly one `sclk` period. It stays low while `en` is low in idle, and it changes only together with a rising edge of `sclk`.
- R3: The first word's bit 15 appears on `sdout` on the rising `sclk` edge that ends `fsync`. Bits follow MSB first, one per rising edge, and `sdout` changes only on rising edges. `sdout` is low while `fsync` is high.
- R4: While `en` stays high, words follow back to back with no further `fsync`. `tx_take` pulses for one system cycle just before each rising edge that loads a new word, and `tx_data` is captured on that cycle.
- R5: If `en` is low at a word boundary, the port finishes the current word and returns to idle. `sdout` and `fsync` are then low, and exactly one `tx_take` was given per word sent.
- R6: `sdin` is sampled on falling `sclk` edges while words stream, MSB first. After the 16th sample of a word, `rx_word` holds the word and `rx_strobe` pulses for one system cycle.
- R7: `rx_flag` toggles once for every GROUP (default 4) received words. It toggles in the same cycle as the `rx_strobe` of the last word of the group, and at no other time.
- R8: Each new stream restarts both the bit count and the group count. Words from an earlier stream that did not fill a group do not count toward the next group.
- R9: While reset is held, `sclk`, `fsync`, `sdout`, `tx_take`, `rx_strobe` and `rx_flag` are all 0.
- R10: A divider value of 0 gives the fastest serial clock, a period of 2 system cycles, and full-word transfers still work at that rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | DIV_W (8) | Serial clock divider value N |
| en | input | 1 | Run request; its rise from idle starts a stream, its fall ends it at a word boundary |
| tx_data | input | WORD_W (16) | Next word to transmit |
| tx_take | output | 1 | One-cycle pulse: `tx_data` is captured this cycle |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync, active high |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |
| rx_word | output | WORD_W (16) | Last complete received word |
| rx_strobe | output | 1 | One-cycle pulse when `rx_word` updates |
| rx_flag | output | 1 | Toggles once per completed group of received words |

## Verification
The completion of a group's last received word and the toggle of the group flag fall on the same system edge, as do the `tx_take` load and the start of the next transmit word. Every stream in the vector table is four words long. Each stream therefore ends exactly on a group boundary, and the bench checks that the flag toggled once and that the toggle came with the fourth strobe, not with an earlier one. A two-word stream followed by a four-word stream shows that the group position restarts: the toggle must land on the fourth word of the new stream and not on its second.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } ssp_state_e;

endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_n,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             tick;

    // Half period ends when the count reaches the divider value.
    assign tick = (cnt_q >= div_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk = sclk_q;
    assign rise = tick & ~sclk_q;
    assign fall = tick & sclk_q;

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rise,
    input  logic fall,
    output logic fsync,
    output logic load,
    output logic shift,
    output logic clear,
    output logic sample,
    output logic restart
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    ssp_state_e state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic             last;

    assign last = (bit_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rise && en)            state_d = ST_SYNC;
            ST_SYNC:  if (rise)                  state_d = ST_SHIFT;
            ST_SHIFT: if (rise && last && !en)   state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SHIFT)
                bit_q <= '0;
            else if (rise)
                bit_q <= last ? '0 : bit_q + 1'b1;
        end
    end

    always_comb begin
        fsync   = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        clear   = 1'b0;
        sample  = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                restart = rise & en;
            end
            ST_SYNC: begin
                fsync = 1'b1;
                load  = rise;
            end
            ST_SHIFT: begin
                load   = rise & last & en;
                shift  = rise & ~last;
                clear  = rise & last & ~en;
                sample = fall;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ssp_txshift.sv
module ssp_txshift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    input  logic [WORD_W-1:0] tx_data,
    output logic              sdout
);

    logic [WORD_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (load)
            sreg_q <= tx_data;
        else if (shift)
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
        else if (clear)
            sreg_q <= '0;
    end

    assign sdout = sreg_q[WORD_W-1];

endmodule

// File: rtl/ssp_rxcollect.sv
module ssp_rxcollect #(
    parameter int WORD_W = 16,
    parameter int GROUP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              restart,
    input  logic              sdin,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_strobe,
    output logic              rx_flag
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam int GRP_W = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUP - 1);

    logic [WORD_W-1:0] rsh_q;
    logic [BIT_W-1:0]  rcnt_q;
    logic [GRP_W-1:0]  gcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsh_q     <= '0;
            rcnt_q    <= '0;
            gcnt_q    <= '0;
            rx_word   <= '0;
            rx_strobe <= 1'b0;
            rx_flag   <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (restart) begin
                rcnt_q <= '0;
                gcnt_q <= '0;
            end else if (sample) begin
                rsh_q <= {rsh_q[WORD_W-2:0], sdin};
                if (rcnt_q == LAST_BIT) begin
                    rcnt_q    <= '0;
                    rx_word   <= {rsh_q[WORD_W-2:0], sdin};
                    rx_strobe <= 1'b1;
                    if (gcnt_q == LAST_GRP) begin
                        gcnt_q  <= '0;
                        rx_flag <= ~rx_flag;
                    end else begin
                        gcnt_q  <= gcnt_q + 1'b1;
                    end
                end else begin
                    rcnt_q <= rcnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ssp_framer.sv
module ssp_framer #(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8,
    parameter int GROUP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              en,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_take,
    output logic              sclk,
    output logic              fsync,
    output logic              sdout,
    input  logic              sdin,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_strobe,
    output logic              rx_flag
);

    logic rise, fall;
    logic load, shift, clear, sample, restart;

    ssp_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div_n (div_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    ssp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .rise    (rise),
        .fall    (fall),
        .fsync   (fsync),
        .load    (load),
        .shift   (shift),
        .clear   (clear),
        .sample  (sample),
        .restart (restart)
    );

    ssp_txshift #(.WORD_W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .clear   (clear),
        .tx_data (tx_data),
        .sdout   (sdout)
    );

    ssp_rxcollect #(.WORD_W(WORD_W), .GROUP(GROUP)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .restart   (restart),
        .sdin      (sdin),
        .rx_word   (rx_word),
        .rx_strobe (rx_strobe),
        .rx_flag   (rx_flag)
    );

    assign tx_take = load;

endmodule

// File: rtl/ssp_framer_chk.sv
module ssp_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_take,
    input logic sclk,
    input logic fsync,
    input logic sdout,
    input logic rx_strobe,
    input logic rx_flag
);

    // R2: frame sync moves only together with a rising serial clock
    assert_fsync_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync != $past(fsync)) |-> (sclk && !$past(sclk)));

    // R3: transmit data moves only together with a rising serial clock
    assert_sdout_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdout != $past(sdout)) |-> (sclk && !$past(sclk)));

    // R3: the data line is quiet during the sync period
    assert_quiet_in_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> !sdout);

    // R4: a word is taken in the cycle just before a rising edge
    assert_take_before_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> (sclk && !$past(sclk)));

    // R7: the group flag only moves with a completed word
    assert_flag_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag != $past(rx_flag)) |-> rx_strobe);

endmodule

bind ssp_framer ssp_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_take   (tx_take),
    .sclk      (sclk),
    .fsync     (fsync),
    .sdout     (sdout),
    .rx_strobe (rx_strobe),
    .rx_flag   (rx_flag)
);

// File: tb/sim_ssp_framer.sv
`timescale 1ns/1ps
module sim_ssp_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_n = 8'd0;
    logic        en = 1'b0;
    logic [15:0] tx_data = 16'd0;
    logic        tx_take, sclk, fsync, sdout;
    logic        sdin = 1'b0;
    logic [15:0] rx_word;
    logic        rx_strobe, rx_flag;

    always #2 clk = ~clk;   // 250 MHz

    ssp_framer u0 (
        .clk(clk), .rst_n(rst_n), .div_n(div_n), .en(en), .tx_data(tx_data),
        .tx_take(tx_take), .sclk(sclk), .fsync(fsync), .sdout(sdout),
        .sdin(sdin), .rx_word(rx_word), .rx_strobe(rx_strobe), .rx_flag(rx_flag)
    );

    // each row: divider, four transmit words, four receive words
    localparam logic [15:0] VEC [0:3][0:8] = '{
        '{16'd0,  16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h1234, 16'hFFFF, 16'h0000, 16'h8001},
        '{16'd1,  16'h5555, 16'hAAAA, 16'h0F0F, 16'hF0F0, 16'hC0DE, 16'h7FFE, 16'h0100, 16'hBEEF},
        '{16'd3,  16'h8001, 16'h7FFE, 16'h1357, 16'h2468, 16'h0001, 16'h8000, 16'hAAAA, 16'h5555},
        '{16'd31, 16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D, 16'h0F1E, 16'h2D3C, 16'h4B5A, 16'h6978}
    };

    int checks = 0, errors = 0;
    bit done = 0;

    logic [15:0] cur_tx [0:3];
    logic [15:0] cur_rx [0:3];
    logic [15:0] got_tx [0:3];
    logic [15:0] got_rx [0:3];
    logic [15:0] shw;
    int cur_div = 0, n_words = 0;
    int idx, takes, wi, nb, rcv, toggles, toggle_at, fs_cnt, per_bad, quiet_bad, rises, per_cnt;
    bit pend, armed, ps, last_flag;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench-side slave and monitor, sampling on the falling system clock
    initial begin
        idx = 0; takes = 0; wi = 0; nb = 0; rcv = 0; toggles = 0; toggle_at = 0;
        fs_cnt = 0; per_bad = 0; quiet_bad = 0; rises = 0; per_cnt = 0;
        pend = 0; armed = 0; ps = 0; last_flag = 0; shw = '0;
        forever begin
            @(negedge clk);
            if (pend) begin
                idx++;
                tx_data = (idx < n_words) ? cur_tx[idx] : 16'd0;
                if (idx >= n_words) en = 1'b0;
                pend = 0;
            end
            if (tx_take) begin
                pend = 1;
                takes++;
            end
            per_cnt++;
            if (sclk && !ps) begin
                if (rises >= 1 && per_cnt != 2 * (cur_div + 1)) per_bad++;
                per_cnt = 0;
                rises++;
                if (fsync) begin
                    fs_cnt++;
                    if (sdout) quiet_bad++;
                    nb = 0;
                    armed = (wi < n_words);
                    sdin = 1'b0;
                end else if (armed) begin
                    shw = {shw[14:0], sdout};
                    sdin = cur_rx[wi][15-nb];
                    nb++;
                    if (nb == 16) begin
                        got_tx[wi] = shw;
                        wi++;
                        nb = 0;
                        if (wi >= n_words) armed = 0;
                    end
                end
            end
            ps = sclk;
            if (rx_strobe) begin
                if (rcv < 4) got_rx[rcv] = rx_word;
                rcv++;
            end
            if (rx_flag != last_flag) begin
                toggles++;
                toggle_at = rcv;
                last_flag = rx_flag;
            end
        end
    end

    task automatic run_stream(input int dv, input int n);
        @(negedge clk);
        cur_div = dv; div_n = 8'(dv);
        idx = 0; takes = 0; pend = 0; wi = 0; nb = 0; armed = 0; rcv = 0;
        toggles = 0; toggle_at = 0; fs_cnt = 0; per_bad = 0; quiet_bad = 0;
        rises = 0; per_cnt = 0;
        tx_data = cur_tx[0];
        n_words = n;
        en = 1'b1;
        for (int g = 0; g < 60000 && !(wi >= n && rcv >= n && !en); g++) @(negedge clk);
        repeat (6 * (dv + 1) + 4) @(negedge clk);
    endtask

    task automatic check_stream(input int n, input int exp_tog, input int exp_at);
        for (int w = 0; w < n; w++) begin
            chk(got_tx[w] == cur_tx[w], "R3 transmit word MSB first", got_tx[w], cur_tx[w]);
            chk(got_rx[w] == cur_rx[w], "R6 receive word", got_rx[w], cur_rx[w]);
        end
        chk(fs_cnt == 1, "R2/R4 one sync per stream", fs_cnt, 1);
        chk(quiet_bad == 0, "R3 sdout low during sync", quiet_bad, 0);
        chk(per_bad == 0, "R1/R10 serial period 2*(N+1)", per_bad, 0);
        chk(takes == n, "R4/R5 one take per word", takes, n);
        chk(rcv == n, "R6 one strobe per word", rcv, n);
        chk(toggles == exp_tog, "R7 group flag toggles", toggles, exp_tog);
        if (exp_tog > 0)
            chk(toggle_at == exp_at, "R7/R8 toggle on last word of group", toggle_at, exp_at);
        chk(!sdout && !fsync, "R5 idle after stop", {sdout, fsync}, 0);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk({sclk, fsync, sdout, tx_take, rx_strobe, rx_flag} == 6'b0, "R9 reset outputs",
            {sclk, fsync, sdout, tx_take, rx_strobe, rx_flag}, 0);
        rst_n = 1'b1;
        // R2: no sync while enable is low; clock keeps running (R1)
        div_n = 8'd2; cur_div = 2; rises = 0; fs_cnt = 0;
        repeat (100) @(negedge clk);
        chk(fs_cnt == 0, "R2 no sync without enable", fs_cnt, 0);
        chk(rises > 0, "R1 serial clock free-running", rises, 1);

        // vector table
        for (int v = 0; v < 4; v++) begin
            for (int k = 0; k < 4; k++) begin
                cur_tx[k] = VEC[v][1+k];
                cur_rx[k] = VEC[v][5+k];
            end
            run_stream(int'(VEC[v][0]), 4);
            check_stream(4, 1, 4);
        end

        // R8: a partial stream does not pre-load the group count
        for (int k = 0; k < 4; k++) begin
            cur_tx[k] = 16'h1111 * 16'(k + 1);
            cur_rx[k] = 16'h9009 ^ 16'(k);
        end
        run_stream(2, 2);
        check_stream(2, 0, 0);
        run_stream(2, 4);
        check_stream(4, 1, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule